// File: doc/BRIEF.md
# Logic-Block Control Signal Generator

This block produces the per-register control signals for one cluster of logic registers. It picks the cluster clock from six row clock lines or one local line. From two shared clock-enable sources, a set of synchronous clear sources and a set of asynchronous clear sources, it builds the enable, synchronous clear and asynchronous clear for each register. A small configuration word per register decides which enable drives the register and which clears reach it.

The shared clears pass through a legality stage. Only a limited number of clear sources may be active at once. When the configuration turns on more than that limit, an error flag is raised and the excess sources are dropped, last in order first. An active-low device-wide clear overrides every other control. It forces all asynchronous clears on and holds the enables and synchronous clears off. It takes effect at once, and its release is synchronised to the cluster clock.

Top module: `lbc_ctrl_gen`

## Requirements
- R1: `blk_clk_o` follows row line `row_clk_i[k]` when `clk_sel_i` equals k for k in 0..5, and follows `local_clk_i` when `clk_sel_i` is 6 or 7.
- R2: The register configuration word has bits [1:0] = enable select, bits [3:2] = synchronous clear mask, and bits [5:4] = asynchronous clear mask. Register n uses bits [6n+5:6n] of `reg_cfg_i`. An enable select of 0 gives `ce_o[n]` = `ce_src_i[0]`, 1 gives `ce_src_i[1]`, and 2 or 3 gives a constant 1.
- R3: Clock enable takes priority over synchronous clear. `sclr_o[n]` is 1 only while `ce_o[n]` is 1 and a live synchronous clear selected by the register's mask is 1.
- R4: `aclr_o[n]` is 1 whenever a live asynchronous clear selected by the register's mask is 1, whatever the enable.
- R5: A clear source whose enable bit (`sclr_en_i`/`aclr_en_i`) is 0, or whose mask bit for the register is 0, has no effect on that register.
- R6: The clear sources are counted in the order sync 0, sync 1, async 0, async 1, and at most three may be enabled. When all four are enabled, `cfg_err_o` is 1 and async clear 1 is ignored. With three or fewer enabled, `cfg_err_o` is 0 and every enabled source acts.
- R7: While `dev_clr_n_i` is 0, every `aclr_o` bit is 1 and every `ce_o` and `sclr_o` bit is 0. This takes effect without waiting for a clock edge.
- R8: After `dev_clr_n_i` rises, the override persists through the first rising edge of `blk_clk_o` and ends at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| row_clk_i | input | 6 | Row clock lines |
| local_clk_i | input | 1 | Clock from local routing |
| clk_sel_i | input | 3 | Cluster clock select |
| dev_clr_n_i | input | 1 | Device-wide clear, active low |
| ce_src_i | input | 2 | Shared clock-enable sources |
| sclr_src_i | input | 2 | Shared synchronous clear sources, active high |
| aclr_src_i | input | 2 | Shared asynchronous clear sources, active high |
| sclr_en_i | input | 2 | Turns each synchronous clear source on |
| aclr_en_i | input | 2 | Turns each asynchronous clear source on |
| reg_cfg_i | input | 48 | Six-bit configuration word per register |
| blk_clk_o | output | 1 | Selected cluster clock |
| ce_o | output | 8 | Per-register clock enable |
| sclr_o | output | 8 | Per-register synchronous clear |
| aclr_o | output | 8 | Per-register asynchronous clear |
| cfg_err_o | output | 1 | Too many clear sources enabled |

## Verification
Some properties hold on every edge of the cluster clock, and the assertions check those:
- the device clear forcing all clears on and all enables off;
- no synchronous clear appearing without its enable;
- the error flag appearing only when the clear limit is exceeded;
- asynchronous clears staying low two edges after release when no source drives them.

Other behaviours need chosen configurations and are shown only by the bench scenarios:
- each enable-select value;
- the dropping of exactly the fourth clear source;
- masking per register;
- the clock line chosen by each select value;
- the exact edge on which the release takes effect.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    localparam int CE_SEL_W = 2;

    typedef enum logic [CE_SEL_W-1:0] {
        CE_FROM_SRC0 = 2'd0,
        CE_FROM_SRC1 = 2'd1,
        CE_ALWAYS    = 2'd2,
        CE_ALWAYS_B  = 2'd3
    } ce_sel_e;
endpackage

// File: rtl/lbc_clk_pick.sv
module lbc_clk_pick #(
    parameter int NROW = 6,
    localparam int SELW = $clog2(NROW + 1)
) (
    input  logic [NROW-1:0] row_clk_i,
    input  logic            local_clk_i,
    input  logic [SELW-1:0] sel_i,
    output logic            clk_o
);
    always_comb begin
        clk_o = local_clk_i;
        for (int i = 0; i < NROW; i++) begin
            if (sel_i == SELW'(i)) clk_o = row_clk_i[i];
        end
    end
endmodule

// File: rtl/lbc_devclr_sync.sv
module lbc_devclr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic dev_clr_n_i,
    output logic dev_active_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk_i or negedge dev_clr_n_i) begin
        if (!dev_clr_n_i) st_q <= '0;
        else              st_q <= st_d;
    end

    assign dev_active_o = ~dev_clr_n_i | ~st_q.chain[STAGES-1];
endmodule

// File: rtl/lbc_clr_limit.sv
module lbc_clr_limit #(
    parameter int NSCLR   = 2,
    parameter int NACLR   = 2,
    parameter int MAX_CLR = 3,
    localparam int CNTW   = $clog2(NSCLR + NACLR + 1)
) (
    input  logic [NSCLR-1:0] sclr_src_i,
    input  logic [NACLR-1:0] aclr_src_i,
    input  logic [NSCLR-1:0] sclr_en_i,
    input  logic [NACLR-1:0] aclr_en_i,
    output logic [NSCLR-1:0] sclr_live_o,
    output logic [NACLR-1:0] aclr_live_o,
    output logic             err_o
);
    logic [CNTW-1:0]  cnt;
    logic [NSCLR-1:0] s_ok;
    logic [NACLR-1:0] a_ok;

    always_comb begin
        cnt  = '0;
        s_ok = '0;
        a_ok = '0;
        for (int i = 0; i < NSCLR; i++) begin
            if (sclr_en_i[i]) begin
                cnt     = cnt + CNTW'(1);
                s_ok[i] = (cnt <= CNTW'(MAX_CLR));
            end
        end
        for (int i = 0; i < NACLR; i++) begin
            if (aclr_en_i[i]) begin
                cnt     = cnt + CNTW'(1);
                a_ok[i] = (cnt <= CNTW'(MAX_CLR));
            end
        end
        err_o = (cnt > CNTW'(MAX_CLR));
    end

    assign sclr_live_o = sclr_src_i & s_ok;
    assign aclr_live_o = aclr_src_i & a_ok;
endmodule

// File: rtl/lbc_reg_slice.sv
module lbc_reg_slice
    import lbc_pkg::*;
#(
    parameter int NSCLR = 2,
    parameter int NACLR = 2,
    localparam int CFGW = CE_SEL_W + NSCLR + NACLR
) (
    input  logic [1:0]       ce_src_i,
    input  logic [NSCLR-1:0] sclr_live_i,
    input  logic [NACLR-1:0] aclr_live_i,
    input  logic             dev_active_i,
    input  logic [CFGW-1:0]  cfg_i,
    output logic             ce_o,
    output logic             sclr_o,
    output logic             aclr_o
);
    ce_sel_e          ce_sel;
    logic [NSCLR-1:0] s_mask;
    logic [NACLR-1:0] a_mask;
    logic             ce_pick;

    assign ce_sel = ce_sel_e'(cfg_i[CE_SEL_W-1:0]);
    assign s_mask = cfg_i[CE_SEL_W +: NSCLR];
    assign a_mask = cfg_i[CE_SEL_W+NSCLR +: NACLR];

    always_comb begin
        unique case (ce_sel)
            CE_FROM_SRC0: ce_pick = ce_src_i[0];
            CE_FROM_SRC1: ce_pick = ce_src_i[1];
            default:      ce_pick = 1'b1;
        endcase
    end

    assign ce_o   = ~dev_active_i & ce_pick;
    assign sclr_o = ~dev_active_i & ce_pick & |(s_mask & sclr_live_i);
    assign aclr_o = dev_active_i | |(a_mask & aclr_live_i);
endmodule

// File: rtl/lbc_ctrl_gen.sv
module lbc_ctrl_gen
    import lbc_pkg::*;
#(
    parameter int NROW    = 6,
    parameter int NREG    = 8,
    parameter int NSCLR   = 2,
    parameter int NACLR   = 2,
    parameter int MAX_CLR = 3,
    parameter int STAGES  = 2,
    localparam int SELW   = $clog2(NROW + 1),
    localparam int CFGW   = CE_SEL_W + NSCLR + NACLR
) (
    input  logic [NROW-1:0]      row_clk_i,
    input  logic                 local_clk_i,
    input  logic [SELW-1:0]      clk_sel_i,
    input  logic                 dev_clr_n_i,
    input  logic [1:0]           ce_src_i,
    input  logic [NSCLR-1:0]     sclr_src_i,
    input  logic [NACLR-1:0]     aclr_src_i,
    input  logic [NSCLR-1:0]     sclr_en_i,
    input  logic [NACLR-1:0]     aclr_en_i,
    input  logic [NREG*CFGW-1:0] reg_cfg_i,
    output logic                 blk_clk_o,
    output logic [NREG-1:0]      ce_o,
    output logic [NREG-1:0]      sclr_o,
    output logic [NREG-1:0]      aclr_o,
    output logic                 cfg_err_o
);
    logic             dev_active;
    logic [NSCLR-1:0] sclr_live;
    logic [NACLR-1:0] aclr_live;

    lbc_clk_pick #(.NROW(NROW)) i_clk_pick (
        .row_clk_i   (row_clk_i),
        .local_clk_i (local_clk_i),
        .sel_i       (clk_sel_i),
        .clk_o       (blk_clk_o)
    );

    lbc_devclr_sync #(.STAGES(STAGES)) i_devclr (
        .clk_i        (blk_clk_o),
        .dev_clr_n_i  (dev_clr_n_i),
        .dev_active_o (dev_active)
    );

    lbc_clr_limit #(.NSCLR(NSCLR), .NACLR(NACLR), .MAX_CLR(MAX_CLR)) i_limit (
        .sclr_src_i  (sclr_src_i),
        .aclr_src_i  (aclr_src_i),
        .sclr_en_i   (sclr_en_i),
        .aclr_en_i   (aclr_en_i),
        .sclr_live_o (sclr_live),
        .aclr_live_o (aclr_live),
        .err_o       (cfg_err_o)
    );

    for (genvar n = 0; n < NREG; n++) begin : g_reg
        lbc_reg_slice #(.NSCLR(NSCLR), .NACLR(NACLR)) i_slice (
            .ce_src_i     (ce_src_i),
            .sclr_live_i  (sclr_live),
            .aclr_live_i  (aclr_live),
            .dev_active_i (dev_active),
            .cfg_i        (reg_cfg_i[n*CFGW +: CFGW]),
            .ce_o         (ce_o[n]),
            .sclr_o       (sclr_o[n]),
            .aclr_o       (aclr_o[n])
        );
    end
endmodule

// File: rtl/lbc_ctrl_gen_chk.sv
module lbc_ctrl_gen_chk #(
    parameter int NREG    = 8,
    parameter int NSCLR   = 2,
    parameter int NACLR   = 2,
    parameter int MAX_CLR = 3
) (
    input logic             blk_clk_o,
    input logic             dev_clr_n_i,
    input logic [NSCLR-1:0] sclr_en_i,
    input logic [NACLR-1:0] aclr_en_i,
    input logic [NACLR-1:0] aclr_src_i,
    input logic [NREG-1:0]  ce_o,
    input logic [NREG-1:0]  sclr_o,
    input logic [NREG-1:0]  aclr_o,
    input logic             cfg_err_o
);
    AST_DEVCLR_OVERRIDE: assert property (@(posedge blk_clk_o)
        !dev_clr_n_i |-> (&aclr_o && ce_o == '0 && sclr_o == '0)); // R7

    AST_SCLR_NEEDS_CE: assert property (@(posedge blk_clk_o) disable iff (!dev_clr_n_i)
        (sclr_o & ~ce_o) == '0); // R3

    AST_ERR_ONLY_OVER_LIMIT: assert property (@(posedge blk_clk_o) disable iff (!dev_clr_n_i)
        cfg_err_o |-> ($countones({sclr_en_i, aclr_en_i}) > MAX_CLR)); // R6

    AST_RELEASED_QUIET: assert property (@(posedge blk_clk_o) disable iff (!dev_clr_n_i)
        ($past(dev_clr_n_i) && $past(dev_clr_n_i, 2) && aclr_src_i == '0) |-> aclr_o == '0); // R8
endmodule

bind lbc_ctrl_gen lbc_ctrl_gen_chk #(
    .NREG(NREG), .NSCLR(NSCLR), .NACLR(NACLR), .MAX_CLR(MAX_CLR)
) i_lbc_chk (
    .blk_clk_o   (blk_clk_o),
    .dev_clr_n_i (dev_clr_n_i),
    .sclr_en_i   (sclr_en_i),
    .aclr_en_i   (aclr_en_i),
    .aclr_src_i  (aclr_src_i),
    .ce_o        (ce_o),
    .sclr_o      (sclr_o),
    .aclr_o      (aclr_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/test_lbc_ctrl_gen.sv
module test_lbc_ctrl_gen;
    localparam int NREG = 8;

    logic       clk = 1'b0;
    logic       run = 1'b0;
    logic [5:0] row_static = '0;
    logic       local_static = 1'b0;
    logic [5:0] row_clk;
    logic       local_clk;
    logic [2:0] clk_sel = 3'd0;
    logic       dev_clr_n = 1'b0;
    logic [1:0] ce_src = '0, sclr_src = '0, aclr_src = '0, sclr_en = '0, aclr_en = '0;
    logic [NREG*6-1:0] reg_cfg = '0;
    logic            blk_clk, cfg_err;
    logic [NREG-1:0] ce, sclr, aclr;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    assign row_clk   = run ? {6{clk}} : row_static;
    assign local_clk = run ? clk : local_static;

    lbc_ctrl_gen i_lbc_ctrl_gen (
        .row_clk_i(row_clk), .local_clk_i(local_clk), .clk_sel_i(clk_sel),
        .dev_clr_n_i(dev_clr_n), .ce_src_i(ce_src), .sclr_src_i(sclr_src),
        .aclr_src_i(aclr_src), .sclr_en_i(sclr_en), .aclr_en_i(aclr_en),
        .reg_cfg_i(reg_cfg), .blk_clk_o(blk_clk), .ce_o(ce), .sclr_o(sclr),
        .aclr_o(aclr), .cfg_err_o(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {ce0,ce1, ss[1:0], as[1:0], se[1:0], ae[1:0], amask, smask, cesel, e_ce,e_s,e_a,e_err}
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1,1'b0, 2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00,2'd0, 1'b1,1'b0,1'b0,1'b0, 4'd2}, // R2 src0
        {1'b1,1'b0, 2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00,2'd1, 1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 src1
        {1'b0,1'b0, 2'b00,2'b00, 2'b00,2'b00, 2'b00,2'b00,2'd2, 1'b1,1'b0,1'b0,1'b0, 4'd2}, // R2 always
        {1'b1,1'b0, 2'b01,2'b00, 2'b01,2'b00, 2'b00,2'b01,2'd0, 1'b1,1'b1,1'b0,1'b0, 4'd3}, // R3 enabled
        {1'b0,1'b0, 2'b01,2'b00, 2'b01,2'b00, 2'b00,2'b01,2'd0, 1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 blocked
        {1'b0,1'b0, 2'b00,2'b10, 2'b00,2'b10, 2'b10,2'b00,2'd0, 1'b0,1'b0,1'b1,1'b0, 4'd4}, // R4
        {1'b1,1'b0, 2'b01,2'b00, 2'b00,2'b00, 2'b00,2'b01,2'd0, 1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 sync off
        {1'b1,1'b0, 2'b00,2'b01, 2'b00,2'b00, 2'b01,2'b00,2'd0, 1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 async off
        {1'b1,1'b0, 2'b00,2'b01, 2'b00,2'b01, 2'b10,2'b00,2'd0, 1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 mask
        {1'b1,1'b0, 2'b00,2'b10, 2'b11,2'b11, 2'b10,2'b00,2'd0, 1'b1,1'b0,1'b0,1'b1, 4'd6}, // R6 dropped
        {1'b1,1'b0, 2'b00,2'b01, 2'b11,2'b11, 2'b01,2'b00,2'd0, 1'b1,1'b0,1'b1,1'b1, 4'd6}, // R6 kept
        {1'b1,1'b0, 2'b00,2'b01, 2'b11,2'b01, 2'b11,2'b00,2'd0, 1'b1,1'b0,1'b1,1'b0, 4'd6}  // R6 three
    };

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R7: reset state while device clear held low
        #1;
        check("R7 reset aclr", 32'(aclr), 32'hFF);
        check("R7 reset ce", 32'(ce), 32'h0);
        // R1: clock select with static lines
        row_static = 6'b101101;
        local_static = 1'b0;
        for (int k = 0; k < 8; k++) begin
            clk_sel = 3'(k);
            #1;
            check($sformatf("R1 sel %0d", k), 32'(blk_clk),
                  32'(k < 6 ? row_static[k] : local_static));
        end
        local_static = 1'b1;
        clk_sel = 3'd7;
        #1 check("R1 local", 32'(blk_clk), 32'd1);
        clk_sel = 3'd0;
        run = 1'b1;
        // R8: release timing
        reg_cfg = {NREG{6'b00_00_10}};
        @(negedge clk) dev_clr_n = 1'b1;
        #1 check("R8 not immediate", 32'(aclr), 32'hFF);
        @(negedge clk) check("R8 after 1st edge", 32'(aclr), 32'hFF);
        @(negedge clk) check("R8 after 2nd edge aclr", 32'(aclr), 32'h0);
        check("R8 after 2nd edge ce", 32'(ce), 32'hFF);
        // vector table: R2..R6
        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            e = VEC[v];
            @(negedge clk);
            ce_src   = {e[22], e[23]};
            sclr_src = e[21:20];
            aclr_src = e[19:18];
            sclr_en  = e[17:16];
            aclr_en  = e[15:14];
            reg_cfg  = {NREG{e[13:8]}};
            #1;
            check($sformatf("R%0d vec %0d ce", e[3:0], v), 32'(ce), e[7] ? 32'hFF : 32'h0);
            check($sformatf("R%0d vec %0d sclr", e[3:0], v), 32'(sclr), e[6] ? 32'hFF : 32'h0);
            check($sformatf("R%0d vec %0d aclr", e[3:0], v), 32'(aclr), e[5] ? 32'hFF : 32'h0);
            check($sformatf("R%0d vec %0d err", e[3:0], v), 32'(cfg_err), 32'(e[4]));
        end
        // R5: per-register masking, only register 3 listens to async clear 0
        @(negedge clk);
        aclr_en = 2'b01; sclr_en = 2'b00; aclr_src = 2'b01;
        reg_cfg = {NREG{6'b00_00_10}};
        reg_cfg[3*6 +: 6] = 6'b01_00_10;
        #1 check("R5 single register", 32'(aclr), 32'h08);
        // R4: async clear independent of enable
        ce_src = 2'b00;
        reg_cfg = {NREG{6'b01_00_00}};
        #1 check("R4 no enable", 32'(aclr), 32'hFF);
        // R7: asynchronous assertion mid-cycle
        aclr_src = 2'b00;
        reg_cfg = {NREG{6'b00_00_10}};
        @(posedge clk); #2;
        dev_clr_n = 1'b0;
        #1;
        check("R7 immediate aclr", 32'(aclr), 32'hFF);
        check("R7 immediate ce", 32'(ce), 32'h0);
        check("R7 immediate sclr", 32'(sclr), 32'h0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule